// File: doc/BRIEF.md
# Single-Cycle Parallel Majority-Logic Decoder for a Cyclic Geometry LDPC Code

This block corrects a received codeword of a short cyclic low-density parity-check code built from the lines of a finite Euclidean geometry. Such a code protects a page of NAND flash. The default code has length 15 and dimension 7. Each bit is covered by four parity checks that are orthogonal on it, so one-step majority logic corrects any pattern of up to two bit errors.

The block stores no full parity-check matrix. A single parameter mask marks where the ones sit in the base row of the circulant check matrix. The received word is expanded into all of its cyclic rotations, which form a data circulant. The rotations picked by the mask are XORed, and that one operation yields the check sum of every row together. The check-sum vector is then expanded into its own circulant. The mask picks the four check sums that cover each bit, and a per-bit vote decides whether that bit flips. The full word is therefore corrected in one decoding cycle. A serial cyclic decoder would need one cycle per bit.

The host presents a word with a valid strobe. One clock later it reads the corrected word, a done strobe and an error flag. Encoding and flash control are handled elsewhere.

Top module: `eg_mlg_decoder`

## Requirements
- R1: Bit i of a 15-bit word is the coefficient of x^i. Codewords are the multiples of g(x) = 1 + x^4 + x^6 + x^7 + x^8. Check row s sums bits s, s+1, s+3 and s+7 modulo 15, which is parameter mask 15'h008B.
- R2: A word with no errors is returned unchanged, with the error flag low.
- R3: A codeword with any single bit inverted is returned as the original codeword.
- R4: A codeword with any two bits inverted is returned as the original codeword.
- R5: A bit is inverted exactly when at least 3 of the 4 check sums that cover it are 1.
- R6: When the valid strobe is high at a rising clock edge, the corrected word, the error flag and a done pulse appear after that same edge and stay until the next edge. Back-to-back words give back-to-back results.
- R7: When the valid strobe is low at an edge, done is low after it, and the corrected word and error flag keep their previous values whatever the input word holds.
- R8: While reset is low, done, the corrected word and the error flag are all zero.
- R9: The error flag is 1 exactly when at least one check sum of the received word is 1. For any pattern of one or two errors this means the flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Received word is present this cycle |
| in_word | input | 15 | Received codeword, bit i = coefficient of x^i |
| out_done | output | 1 | One-cycle pulse: result registers were loaded at the last edge |
| out_word | output | 15 | Corrected codeword |
| out_err | output | 1 | At least one check sum of the received word was nonzero |

## Verification
Every result is due exactly one clock after the edge that samples its valid strobe. The decode path is combinational into a single register stage. The driver changes inputs on falling edges and pushes the expected word and flag into a queue. The monitor looks one time unit after each rising edge. It pops one entry whenever a word was sampled at that edge. At the other edges it requires done to be low and the outputs unchanged. This pins both the latency and the hold behaviour to the exact cycle.

// File: rtl/eg_ldpc_pkg.sv
package eg_ldpc_pkg;

  // Default code: length 15, base check row has ones at 0,1,3,7.
  localparam int unsigned DEF_LEN  = 15;
  localparam logic [14:0] DEF_ROW  = 15'h008B;

  // Number of ones in a mask (masks up to 128 bits).
  function automatic int unsigned ones_in(input logic [127:0] m);
    int unsigned c;
    c = 0;
    for (int i = 0; i < 128; i++) begin
      if (m[i]) c = c + 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/eg_circulant.sv
// Expands a vector into all its cyclic rotations: rows[k][i] = vec[(i+k) mod N].
module eg_circulant #(
  parameter int unsigned N = 15
) (
  input  logic [N-1:0]         vec,
  output logic [N-1:0][N-1:0]  rows
);
  for (genvar k = 0; k < N; k++) begin : g_row
    for (genvar i = 0; i < N; i++) begin : g_bit
      assign rows[k][i] = vec[(i + k) % N];
    end
  end
endmodule

// File: rtl/eg_checksum.sv
// Forms every check sum at once by XOR of the rotations picked by the mask.
module eg_checksum #(
  parameter int unsigned N        = 15,
  parameter logic [N-1:0] ROW_MASK = '0
) (
  input  logic [N-1:0][N-1:0] data_rows,
  output logic [N-1:0]        syn
);
  always_comb begin
    syn = '0;
    for (int p = 0; p < N; p++) begin
      if (ROW_MASK[p]) syn = syn ^ data_rows[p];
    end
  end
endmodule

// File: rtl/eg_vote.sv
// Per-bit majority over the orthogonal check sums covering that bit.
// Bit j is covered by rows j-p for every p in the mask, i.e. rotation (N-p) mod N.
module eg_vote #(
  parameter int unsigned  N        = 15,
  parameter logic [N-1:0] ROW_MASK = '0,
  parameter int unsigned  CNT_W    = 3,
  parameter int unsigned  VOTE_MIN = 3
) (
  input  logic [N-1:0][N-1:0] syn_rows,
  output logic [N-1:0]        flip
);
  for (genvar j = 0; j < N; j++) begin : g_bit
    logic [CNT_W-1:0] cnt;
    always_comb begin
      cnt = '0;
      for (int p = 0; p < N; p++) begin
        if (ROW_MASK[p]) cnt = cnt + CNT_W'(syn_rows[(N - p) % N][j]);
      end
    end
    assign flip[j] = (32'(cnt) >= VOTE_MIN);
  end
endmodule

// File: rtl/eg_mlg_decoder.sv
module eg_mlg_decoder
  import eg_ldpc_pkg::*;
#(
  parameter int unsigned  N        = DEF_LEN,
  parameter logic [N-1:0] ROW_MASK = DEF_ROW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [N-1:0] in_word,
  output logic         out_done,
  output logic [N-1:0] out_word,
  output logic         out_err
);
  localparam int unsigned CHK_W    = ones_in(128'(ROW_MASK));
  localparam int unsigned VOTE_MIN = CHK_W / 2 + 1;
  localparam int unsigned CNT_W    = $clog2(CHK_W + 1);

  logic [N-1:0][N-1:0] data_rows;
  logic [N-1:0][N-1:0] syn_rows;
  logic [N-1:0]        syn;
  logic [N-1:0]        flip;

  logic [N-1:0] word_nxt, word_q;
  logic         err_nxt,  err_q;
  logic         done_nxt, done_q;
  logic         load_en;

  eg_circulant #(.N(N)) u_data_circ (
    .vec  (in_word),
    .rows (data_rows)
  );

  eg_checksum #(.N(N), .ROW_MASK(ROW_MASK)) u_chk (
    .data_rows (data_rows),
    .syn       (syn)
  );

  eg_circulant #(.N(N)) u_syn_circ (
    .vec  (syn),
    .rows (syn_rows)
  );

  eg_vote #(.N(N), .ROW_MASK(ROW_MASK), .CNT_W(CNT_W), .VOTE_MIN(VOTE_MIN)) u_vote (
    .syn_rows (syn_rows),
    .flip     (flip)
  );

  // Next-state
  always_comb begin
    load_en  = in_valid;
    word_nxt = in_word ^ flip;
    err_nxt  = |syn;
    done_nxt = in_valid;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= done_nxt;
      if (load_en) begin
        word_q <= word_nxt;
        err_q  <= err_nxt;
      end
    end
  end

  assign out_done = done_q;
  assign out_word = word_q;
  assign out_err  = err_q;

endmodule

// File: rtl/eg_mlg_decoder_chk.sv
module eg_mlg_decoder_chk #(
  parameter int unsigned N = 15
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [N-1:0] in_word,
  input logic         out_done,
  input logic [N-1:0] out_word,
  input logic         out_err
);
  p_done_after_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_done);

  p_no_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_done);

  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_word) && $stable(out_err)));

  p_clean_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_err || (out_word == $past(in_word))));

  p_zero_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_word == '0)) |=> (!out_err && (out_word == '0)));

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r8: assert (!out_done && !out_err && (out_word == '0));
    end
  end
endmodule

bind eg_mlg_decoder eg_mlg_decoder_chk #(.N(N)) u_chk_bind (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_word  (in_word),
  .out_done (out_done),
  .out_word (out_word),
  .out_err  (out_err)
);

// File: tb/eg_mlg_decoder_test.sv
module eg_mlg_decoder_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 15;
  localparam logic [N-1:0] GEN = 15'h01D1; // R1: 1 + x^4 + x^6 + x^7 + x^8

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [N-1:0] in_word = '0;
  logic         out_done;
  logic [N-1:0] out_word;
  logic         out_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  eg_mlg_decoder uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .out_done(out_done), .out_word(out_word), .out_err(out_err)
  );

  typedef struct {
    logic [N-1:0] word;
    logic         err;
    string        req;
  } exp_t;

  exp_t         q[$];
  int           n_checks = 0;
  int           n_fail   = 0;
  bit           started  = 1'b0;
  logic [N-1:0] last_word = '0;
  logic         last_err  = 1'b0;

  function automatic logic [N-1:0] encode(input logic [6:0] m);
    logic [N-1:0] c;
    c = '0;
    for (int i = 0; i < 7; i++) if (m[i]) c = c ^ (GEN << i);
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic send(input logic [N-1:0] w, input logic [N-1:0] ew, input logic ee, input string req);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    e.word = ew; e.err = ee; e.req = req;
    q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    in_word  = N'($urandom);
  endtask

  // Monitor: result of the edge just passed
  always @(posedge clk) begin
    #1;
    if (rst_n && started) begin
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(out_done == 1'b1, "R6 done", {14'b0, out_done}, 15'd1);
        check(out_word == e.word, e.req, out_word, e.word);
        check(out_err == e.err, "R9 err flag", {14'b0, out_err}, {14'b0, e.err});
        last_word = e.word;
        last_err  = e.err;
      end else begin
        check(out_done == 1'b0, "R7 done idle", {14'b0, out_done}, 15'd0);
        check(out_word == last_word && out_err == last_err, "R7 hold",
              out_word, last_word);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [6:0] msgs [6];
    int cnt;
    msgs[0] = 7'h00; msgs[1] = 7'h7F; msgs[2] = 7'h55;
    msgs[3] = 7'($urandom); msgs[4] = 7'($urandom); msgs[5] = 7'($urandom);

    // R8: reset state, with input activity that must not matter
    in_valid = 1'b1;
    in_word  = 15'h7FFF;
    repeat (3) @(posedge clk);
    #1;
    check(out_done == 1'b0, "R8 done in reset", {14'b0, out_done}, 15'd0);
    check(out_word == '0, "R8 word in reset", out_word, 15'd0);
    check(out_err == 1'b0, "R8 err in reset", {14'b0, out_err}, 15'd0);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b1;
    started = 1'b1;
    idle();
    idle();

    cnt = 0;
    foreach (msgs[m]) begin
      logic [N-1:0] c;
      c = encode(msgs[m]);
      send(c, c, 1'b0, "R1/R2 clean word");
      for (int a = 0; a < N; a++) begin
        send(c ^ (N'(1) << a), c, 1'b1, "R3/R5 single error");
        cnt++;
        if (cnt % 7 == 0) begin idle(); idle(); end
      end
      for (int a = 0; a < N; a++) begin
        for (int b = a + 1; b < N; b++) begin
          send(c ^ (N'(1) << a) ^ (N'(1) << b), c, 1'b1, "R4/R5 double error");
          cnt++;
          if (cnt % 11 == 0) idle();
        end
      end
      idle();
    end
    idle(); idle(); idle();

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule